// File: doc/BRIEF.md
# Secure-Aware Private Interrupt Enable Register

This block holds one forwarding-enable flag for each of 32 private interrupts. The low half of the vector belongs to software-generated interrupts and the high half to peripheral interrupts. Bit x of the enable vector tells the downstream forwarding logic whether interrupt x may be passed on. Software reaches the flags through a small register-bus slave port that exposes two views at fixed offsets. A write of 1 to the set view turns a flag on. A write of 1 to the clear view turns it off. Either view reads back the current flags.

Every access is filtered bit by bit. Each interrupt carries a security-group bit. Each security state has its own affinity-routing enable, and a bit whose state has routing switched off is invisible. With the global security-disable control low, a non-secure access cannot see or touch secure-group bits. With that control high, a non-secure access is limited only by routing. Bits that an access cannot reach read as zero, and writes to them are dropped.

Top module: `irq_fwd_enable_reg`

## Requirements
- R1: During and right after reset every bit of `enable_o` is 0.
- R2: Bit x of the register maps to bit x of `enable_o`. Bits 15:0 are the software-generated interrupts and bits 31:16 the peripheral interrupts, and both halves can be set on their own.
- R3: A write to the set view at offset 0x100 sets each reachable bit whose write-data bit is 1. Write-data bits that are 0 leave their flag unchanged.
- R4: A read strobe on either view returns `enable_o` ANDed with the access's reachable mask, combinationally, in the same cycle as the strobe.
- R5: A write to the clear view at offset 0x180 clears each reachable bit whose write-data bit is 1. Write-data bits that are 0 leave their flag unchanged.
- R6: `enable_o` changes only on the clock edge that samples an accepted write, and otherwise holds its value.
- R7: `grp_secure_i[x]` = 1 marks interrupt x as secure-group and 0 as non-secure-group. A bit whose group's routing enable (`route_sec_i` or `route_nsec_i`) is 0 reads as 0 and ignores writes, for any access.
- R8: With `sec_dis_i` = 0, a non-secure access (`bus_nsec_i` = 1) reads 0 from secure-group bits and cannot change them.
- R9: With `sec_dis_i` = 1, a non-secure access reaches every bit that routing allows, secure-group bits included.
- R10: An access to any other offset reads 0 and changes nothing. `bus_rdata_o` is 0 whenever `bus_re_i` is low.
- R11: A secure access (`bus_nsec_i` = 0) reaches every bit that routing allows, whatever `sec_dis_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_addr_i | input | 12 | Byte offset within the register frame |
| bus_wdata_i | input | 32 | Write data, one bit per interrupt |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_nsec_i | input | 1 | 1 = non-secure access |
| bus_rdata_o | output | 32 | Read data, masked per bit |
| grp_secure_i | input | 32 | Per-interrupt group, 1 = secure |
| sec_dis_i | input | 1 | Global security disable |
| route_sec_i | input | 1 | Affinity routing enabled for the secure state |
| route_nsec_i | input | 1 | Affinity routing enabled for the non-secure state |
| enable_o | output | 32 | Forwarding enables to downstream logic |

## Verification
The bench builds the block with its default parameters: 32 interrupts, 16 of them software-generated, a 12-bit offset, and the views at 0x100 and 0x180. This puts the two halves of the vector, the lowest and highest bit, and the mapped and unmapped offsets all within one compact frame. Group vectors that split the halves make every combination of access security, security-disable and per-state routing show a visible difference at both the read port and the enable output.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

    // Which register view an access selects
    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,
        VIEW_SET  = 2'd1,
        VIEW_CLR  = 2'd2
    } view_e;

endpackage

// File: rtl/irq_view_decode.sv
module irq_view_decode
    import irq_en_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] SET_OFS = 12'h100,
    parameter logic [ADDR_W-1:0] CLR_OFS = 12'h180
) (
    input  logic [ADDR_W-1:0] addr_i,
    output view_e             view_o
);

    always_comb begin
        if (addr_i == SET_OFS) begin
            view_o = VIEW_SET;
        end else if (addr_i == CLR_OFS) begin
            view_o = VIEW_CLR;
        end else begin
            view_o = VIEW_NONE;
        end
    end

endmodule

// File: rtl/irq_access_mask.sv
module irq_access_mask #(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] grp_secure_i,
    input  logic               nsec_i,
    input  logic               sec_dis_i,
    input  logic               route_sec_i,
    input  logic               route_nsec_i,
    output logic [NUM_IRQ-1:0] mask_o
);

    // A non-secure access is barred from secure-group bits unless security is disabled
    logic ns_barred;
    assign ns_barred = nsec_i & ~sec_dis_i;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
        logic routed;
        assign routed    = grp_secure_i[g] ? route_sec_i : route_nsec_i;
        assign mask_o[g] = routed & ~(grp_secure_i[g] & ns_barred);
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] en_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (set_i[i]) begin
                st_d.en[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.en[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/irq_fwd_enable_reg.sv
module irq_fwd_enable_reg
    import irq_en_pkg::*;
#(
    parameter int                NUM_IRQ = 32,
    parameter int                NUM_SGI = 16,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] SET_OFS = 12'h100,
    parameter logic [ADDR_W-1:0] CLR_OFS = 12'h180
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_IRQ-1:0] bus_wdata_i,
    input  logic               bus_we_i,
    input  logic               bus_re_i,
    input  logic               bus_nsec_i,
    output logic [NUM_IRQ-1:0] bus_rdata_o,
    input  logic [NUM_IRQ-1:0] grp_secure_i,
    input  logic               sec_dis_i,
    input  logic               route_sec_i,
    input  logic               route_nsec_i,
    output logic [NUM_IRQ-1:0] enable_o
);

    localparam int NUM_PPI = NUM_IRQ - NUM_SGI;

    view_e              view;
    logic [NUM_IRQ-1:0] reach;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_vec;
    logic [NUM_IRQ-1:0] en_q;
    logic               wr_hit;

    irq_view_decode #(
        .ADDR_W (ADDR_W),
        .SET_OFS(SET_OFS),
        .CLR_OFS(CLR_OFS)
    ) i_decode (
        .addr_i(bus_addr_i),
        .view_o(view)
    );

    irq_access_mask #(
        .NUM_IRQ(NUM_IRQ)
    ) i_mask (
        .grp_secure_i(grp_secure_i),
        .nsec_i      (bus_nsec_i),
        .sec_dis_i   (sec_dis_i),
        .route_sec_i (route_sec_i),
        .route_nsec_i(route_nsec_i),
        .mask_o      (reach)
    );

    assign wr_hit = bus_we_i & (view != VIEW_NONE);

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (wr_hit) begin
            if (view == VIEW_SET) begin
                set_vec = bus_wdata_i & reach;
            end else begin
                clr_vec = bus_wdata_i & reach;
            end
        end
    end

    irq_enable_bank #(
        .NUM_IRQ(NUM_IRQ)
    ) i_bank (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .en_o  (en_q)
    );

    // Read data: both views return the same masked state
    always_comb begin
        if (bus_re_i && (view != VIEW_NONE)) begin
            bus_rdata_o = en_q & reach;
        end else begin
            bus_rdata_o = '0;
        end
    end

    // Software-generated and peripheral halves drive the same output vector
    logic [NUM_SGI-1:0] sgi_en;
    logic [NUM_PPI-1:0] ppi_en;
    assign sgi_en   = en_q[NUM_SGI-1:0];
    assign ppi_en   = en_q[NUM_IRQ-1:NUM_SGI];
    assign enable_o = {ppi_en, sgi_en};

endmodule

// File: rtl/irq_fwd_enable_chk.sv
module irq_fwd_enable_chk #(
    parameter int                NUM_IRQ = 32,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] SET_OFS = 12'h100,
    parameter logic [ADDR_W-1:0] CLR_OFS = 12'h180
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [NUM_IRQ-1:0] bus_wdata_i,
    input logic               bus_we_i,
    input logic               bus_re_i,
    input logic               bus_nsec_i,
    input logic [NUM_IRQ-1:0] bus_rdata_o,
    input logic [NUM_IRQ-1:0] grp_secure_i,
    input logic               sec_dis_i,
    input logic               route_sec_i,
    input logic               route_nsec_i,
    input logic [NUM_IRQ-1:0] enable_o
);

    // Bits whose security state has routing enabled
    logic [NUM_IRQ-1:0] routed_v;
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            routed_v[i] = grp_secure_i[i] ? route_sec_i : route_nsec_i;
        end
    end

    logic set_wr, clr_wr, any_wr;
    assign set_wr = bus_we_i && (bus_addr_i == SET_OFS);
    assign clr_wr = bus_we_i && (bus_addr_i == CLR_OFS);
    assign any_wr = set_wr || clr_wr;

    // R1: outputs are clear on leaving reset
    a_r1_reset_clear: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (enable_o == '0));

    // R3: set view only raises bits that were written with 1
    a_r3_set_only_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_wr |=> (((enable_o & ~$past(enable_o) & ~$past(bus_wdata_i)) == '0)
                 && (($past(enable_o) & ~enable_o) == '0)));

    // R4: read data never shows a bit that is not enabled
    a_r4_read_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_re_i |-> ((bus_rdata_o & ~enable_o) == '0));

    // R5: clear view only lowers bits that were written with 1
    a_r5_clear_only_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr |=> (((~enable_o & $past(enable_o) & ~$past(bus_wdata_i)) == '0)
                 && ((enable_o & ~$past(enable_o)) == '0)));

    // R6: no mapped write, no change
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_wr |=> $stable(enable_o));

    // R7: unrouted bits are never modified
    a_r7_unrouted_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_wr |=> (((enable_o ^ $past(enable_o)) & ~$past(routed_v)) == '0));

    // R7: unrouted bits read as zero
    a_r7_unrouted_rdz: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_re_i |-> ((bus_rdata_o & ~routed_v) == '0));

    // R8: non-secure access without security disable leaves secure bits alone
    a_r8_ns_secure_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_wr && bus_nsec_i && !sec_dis_i)
            |=> (((enable_o ^ $past(enable_o)) & $past(grp_secure_i)) == '0));

    a_r8_ns_secure_rdz: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_nsec_i && !sec_dis_i) |-> ((bus_rdata_o & grp_secure_i) == '0));

    // R10: idle or unmapped reads return zero
    a_r10_quiet_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_re_i || ((bus_addr_i != SET_OFS) && (bus_addr_i != CLR_OFS)))
            |-> (bus_rdata_o == '0));

endmodule

bind irq_fwd_enable_reg irq_fwd_enable_chk #(
    .NUM_IRQ(NUM_IRQ),
    .ADDR_W (ADDR_W),
    .SET_OFS(SET_OFS),
    .CLR_OFS(CLR_OFS)
) i_chk (.*);

// File: tb/test_irq_fwd_enable_reg.sv
module test_irq_fwd_enable_reg;

    localparam int          N      = 32;
    localparam int          AW     = 12;
    localparam logic [11:0] A_SET  = 12'h100;
    localparam logic [11:0] A_CLR  = 12'h180;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [N-1:0]  wdata;
    logic          we, re, nsec;
    logic [N-1:0]  rdata;
    logic [N-1:0]  grp;
    logic          sdis, rt_s, rt_ns;
    logic [N-1:0]  en;

    always #5 clk = ~clk;

    irq_fwd_enable_reg i_irq_fwd_enable_reg (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_nsec_i  (nsec),
        .bus_rdata_o (rdata),
        .grp_secure_i(grp),
        .sec_dis_i   (sdis),
        .route_sec_i (rt_s),
        .route_nsec_i(rt_ns),
        .enable_o    (en)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [N-1:0] ref_en;

    // Which bits the present access may reach, per the requirements
    function automatic logic [N-1:0] model_reach();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            bit ok;
            if (grp[i]) ok = rt_s; else ok = rt_ns;
            if (nsec && !sdis && grp[i]) ok = 0;
            r[i] = ok;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: read checked mid-cycle, model updated at the edge, output checked after
    task automatic cycle(string tag, bit w, bit r, logic [11:0] a, logic [N-1:0] d, bit ns);
        logic [N-1:0] exp_rd;
        logic [N-1:0] m;
        we = w; re = r; addr = a; wdata = d; nsec = ns;
        #1;
        exp_rd = (r && (a == A_SET || a == A_CLR)) ? (ref_en & model_reach()) : '0;
        chk({tag, " rdata"}, rdata, exp_rd);
        @(posedge clk);
        if (w) begin
            m = model_reach();
            if (a == A_SET)      ref_en = ref_en | (d & m);
            else if (a == A_CLR) ref_en = ref_en & ~(d & m);
        end
        @(negedge clk);
        chk({tag, " enable"}, en, ref_en);
        we = 0; re = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; we = 0; re = 1; nsec = 0; addr = A_SET; wdata = '1;
        grp = 32'h0000_FFFF; sdis = 0; rt_s = 1; rt_ns = 1;
        ref_en = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset enable", en, '0);
        chk("R1 reset rdata", rdata, '0);
        rst_n = 1;
        re = 0;
        @(negedge clk);
        chk("R1 after reset", en, '0);

        // R2/R3: lowest software bit and highest peripheral bit, secure access
        cycle("R2 set bit0", 1, 0, A_SET, 32'h0000_0001, 0);
        cycle("R2 set bit31", 1, 0, A_SET, 32'h8000_0000, 0);
        cycle("R3 zeros no effect", 1, 0, A_SET, 32'h0000_0000, 0);
        cycle("R3 set pattern", 1, 1, A_SET, 32'h00F0_0F00, 0);
        // R4: both views read the same state
        cycle("R4 read set view", 0, 1, A_SET, '0, 0);
        cycle("R4 read clr view", 0, 1, A_CLR, '0, 0);
        // R5: clear view
        cycle("R5 clear bit0", 1, 1, A_CLR, 32'h0000_0001, 0);
        cycle("R5 clear zeros", 1, 0, A_CLR, 32'h0000_0000, 0);
        // R6: idle cycles hold
        for (int k = 0; k < 3; k++) cycle("R6 idle hold", 0, 0, A_SET, 32'hFFFF_FFFF, 0);
        // R8: non-secure, security enabled, secure group on low half
        cycle("R8 ns set all", 1, 1, A_SET, 32'hFFFF_FFFF, 1);
        cycle("R8 ns read", 0, 1, A_SET, '0, 1);
        cycle("R8 ns clear all", 1, 0, A_CLR, 32'hFFFF_FFFF, 1);
        cycle("R8 ns read clr", 0, 1, A_CLR, '0, 1);
        // R11: secure access reaches secure group, with and without sdis
        cycle("R11 sec read", 0, 1, A_SET, '0, 0);
        sdis = 1;
        cycle("R11 sec set low", 1, 1, A_SET, 32'h0000_00FF, 0);
        // R9: security disabled, non-secure reaches everything routed
        cycle("R9 ns set all", 1, 1, A_SET, 32'hFFFF_FFFF, 1);
        cycle("R9 ns clear low", 1, 1, A_CLR, 32'h0000_F00F, 1);
        // R7: routing off for non-secure state
        rt_ns = 0;
        cycle("R7 ns-group unrouted read", 0, 1, A_SET, '0, 0);
        cycle("R7 ns-group unrouted clr", 1, 1, A_CLR, 32'hFFFF_FFFF, 0);
        rt_ns = 1;
        cycle("R7 restored read", 0, 1, A_CLR, '0, 0);
        rt_s = 0;
        cycle("R7 sec-group unrouted set", 1, 1, A_SET, 32'h0000_FFFF, 1);
        cycle("R7 sec-group unrouted read", 0, 1, A_SET, '0, 0);
        rt_s = 1;
        // R10: unmapped offsets
        cycle("R10 unmapped write", 1, 1, 12'h104, 32'hFFFF_FFFF, 0);
        cycle("R10 unmapped clr", 1, 1, 12'h080, 32'hFFFF_FFFF, 0);
        cycle("R10 no strobe", 0, 0, A_SET, '0, 0);
        // Mixed groups and a final sweep
        grp = 32'hA5A5_5A5A; sdis = 0;
        cycle("R8 mixed ns set", 1, 1, A_SET, 32'hFFFF_FFFF, 1);
        cycle("R11 mixed sec clr", 1, 1, A_CLR, 32'h0F0F_0F0F, 0);
        cycle("R4 mixed read", 0, 1, A_SET, '0, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule